// File: doc/BRIEF.md
# Conversion Settling and Ready Controller

This block sits between a sigma-delta decimation filter and the host-side reader. It receives every raw filter result together with a one-cycle strobe and decides which of those results become published conversions. A published result is copied into an output register, and an active-low ready line tells the host that a fresh word can be read.

The block compares the active configuration on every clock. That configuration is the channel select, gain code, rate code, filter order and latency mode. It operates in one of two latency modes:

- **Free-running mode:** any configuration change discards results until the filter has produced as many outputs as its order (three for the third-order filter, four for the fourth-order filter). Only the last of those outputs is published.
- **Zero-latency mode:** every filter output already spans a full settling window, so every output is published and a change costs nothing.

A low level on the active-low sync input restarts the conversion process. A step on the analog input alone is not detected, so such conversions keep flowing with no flag.

Ready is driven high during the cycle in which the register is being rewritten. It falls one cycle later. It rises again when the host signals that it has finished reading, or when the next result is about to replace the word.

Top module: `conv_ready_ctrl`

## Requirements
- R1: After reset, `drdy_n` is 1, `settled` is 0 and `dout` is 0, and the block counts a full settling window before the first publish.
- R2: In free-running mode (`zero_lat`=0) with the fourth-order filter (`order4`=1), the first three strobes after reset, a change or a sync release are discarded. The fourth is published and `settled` becomes 1.
- R3: In free-running mode with the third-order filter (`order4`=0), the first two strobes after a change are discarded. The third is published and `settled` becomes 1.
- R4: Once settled in free-running mode, every strobe is published, whatever its data, including data that jumps with no configuration change. `settled` stays 1.
- R5: In free-running mode, a change of `cfg_chan`, `cfg_gain`, `cfg_rate`, `order4` or `zero_lat` clears `settled`, forces `drdy_n` to 1 at the next edge and restarts the count. A strobe in the same cycle as the change is discarded.
- R6: A change that arrives while the block is still settling restarts the count from zero.
- R7: In zero-latency mode (`zero_lat`=1), every strobe is published, including one in the cycle of a configuration change, and `settled` stays 1.
- R8: While `sync_n` is 0, strobes are ignored, `drdy_n` is 1 and `settled` is 0. After release, the block needs a full settling window in free-running mode, and it publishes the first strobe in zero-latency mode.
- R9: A published strobe loads `dout` and drives `drdy_n` to 1 at the next clock edge. `drdy_n` falls to 0 one edge later. `dout` changes only on a publish.
- R10: A `rd_done` pulse while `drdy_n` is 0 returns `drdy_n` to 1 at the next edge and leaves `dout` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| filt_valid | input | 1 | One-cycle strobe marking a new raw filter result |
| filt_data | input | DATA_W | Raw filter result |
| cfg_chan | input | CHAN_W | Active channel select |
| cfg_gain | input | GAIN_W | Active gain code |
| cfg_rate | input | RATE_W | Active output rate code |
| order4 | input | 1 | Filter order: 1 = fourth order, 0 = third order |
| zero_lat | input | 1 | Latency mode: 1 = zero-latency, 0 = free-running |
| sync_n | input | 1 | Active-low restart of the conversion process |
| rd_done | input | 1 | Host finished reading the published word |
| drdy_n | output | 1 | Active-low data ready |
| dout | output | DATA_W | Published conversion |
| settled | output | 1 | Filter settled for the current configuration |

## Verification
The bench uses the default parameters: a 24-bit result, a 4-bit channel, a 3-bit gain, a 10-bit rate code, and settling lengths of 3 and 4. With settling lengths that short, every window can be walked strobe by strobe, and each discarded and published output is checked exactly. At these values, a restart in the middle of a window, a switch of order and both sync paths all fit into a few hundred cycles.

// File: rtl/conv_ready_pkg.sv
// Shared types for the settling and ready controller.
// Assumes nothing beyond the encoding of the filter order input.
package conv_ready_pkg;

    typedef enum logic {
        FILT_SINC3 = 1'b0,
        FILT_SINC4 = 1'b1
    } filt_order_e;

    // Larger of two settling lengths, used to size the counter.
    function automatic int max_len(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfg_change_det.sv
// Configuration change detector.
// Holds a copy of the packed configuration word and flags any cycle in
// which the live value differs from it. The copy is refreshed every
// clock, including during reset, so leaving reset never raises a flag.
module cfg_change_det #(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_now,
    output logic             chg
);

    logic [CFG_W-1:0] cfg_q;

    // Track the live configuration one cycle behind.
    always_ff @(posedge clk) begin
        cfg_q <= cfg_now;
    end

    // Flag a difference between the live and the stored configuration.
    always_comb begin
        chg = (cfg_now != cfg_q);
    end

    // R5: a configuration held since the previous edge never counts as a change.
    a_r5_stable_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg_now) |-> !chg);

endmodule

// File: rtl/settle_ctrl.sv
// Settling sequencer.
// Counts filter strobes after a restart (reset, sync or, in free-running
// mode, a configuration change) and decides which strobe is published.
// Assumes filt_valid is a single-cycle strobe and chg comes from the
// change detector in the same cycle as the new configuration.
module settle_ctrl
    import conv_ready_pkg::*;
#(
    parameter int S3_LEN = 3,
    parameter int S4_LEN = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strobe,
    input  logic        chg,
    input  logic        zero_lat,
    input  filt_order_e order_sel,
    input  logic        sync_n,
    output logic        publish,
    output logic        flush,
    output logic        settled
);

    localparam int MAX_LEN = max_len(S3_LEN, S4_LEN);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] need_len;
    logic             last_one;

    // Settling length for the selected filter order and the count of this strobe.
    always_comb begin
        need_len = (order_sel == FILT_SINC4) ? CNT_W'(S4_LEN) : CNT_W'(S3_LEN);
        cnt_inc  = cnt + 1'b1;
        last_one = (cnt_inc == need_len);
    end

    // Decide publication and the ready-line flush for this cycle.
    always_comb begin
        flush   = !sync_n || (chg && !zero_lat);
        publish = sync_n && strobe &&
                  (zero_lat || (!chg && (settled || last_one)));
    end

    // Advance the strobe count and the settled state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            settled <= 1'b0;
        end else if (!sync_n) begin
            cnt     <= '0;
            settled <= 1'b0;
        end else if (chg) begin
            cnt     <= '0;
            settled <= zero_lat ? (settled | strobe) : 1'b0;
        end else if (strobe) begin
            if (zero_lat) begin
                cnt     <= '0;
                settled <= 1'b1;
            end else if (!settled) begin
                if (last_one) begin
                    cnt     <= '0;
                    settled <= 1'b1;
                end else begin
                    cnt <= cnt_inc;
                end
            end
        end
    end

    // R2: the count never reaches the settling length outside a change cycle.
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !chg |-> (cnt < need_len));

    // R5: a free-running change clears the settled state.
    a_r5_change_unsettles: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && !zero_lat && sync_n) |=> !settled);

    // R8: sync low leaves the block unsettled and publishing nothing.
    a_r8_sync_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_n |-> (!publish ##1 !settled));

    // R7: in zero-latency mode a strobe always leaves the block settled.
    a_r7_zero_settles: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_lat && sync_n && strobe) |=> settled);

endmodule

// File: rtl/ready_out.sv
// Output register and active-low ready line.
// Loads the published word, drives ready high while the word is being
// rewritten and drops it one cycle later. A host read-complete or a
// flush returns it high. Assumes publish and flush are never both set.
module ready_out #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              publish,
    input  logic              flush,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] dout,
    output logic              drdy_n
);

    logic pend;

    // Ready line and pending-announce state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drdy_n <= 1'b1;
            pend   <= 1'b0;
        end else if (flush) begin
            drdy_n <= 1'b1;
            pend   <= 1'b0;
        end else if (publish) begin
            drdy_n <= 1'b1;
            pend   <= 1'b1;
        end else if (pend) begin
            drdy_n <= 1'b0;
            pend   <= 1'b0;
        end else if (rd_done) begin
            drdy_n <= 1'b1;
        end
    end

    // Capture the published word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (publish) begin
            dout <= data_in;
        end
    end

    // R9: ready is high in the cycle after a publish.
    a_r9_high_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        publish |=> drdy_n);

    // R9: an announced word lowers ready unless interrupted.
    a_r9_low_after: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !flush && !publish) |=> !drdy_n);

    // R9: the output word moves only on a publish.
    a_r9_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !publish |=> $stable(dout));

    // R5: a flush raises ready at the next edge.
    a_r5_flush_high: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> drdy_n);

endmodule

// File: rtl/conv_ready_ctrl.sv
// Conversion settling and ready controller, top level.
// Packs the configuration for change detection, sequences settling and
// drives the published word and ready line. Assumes all inputs are
// synchronous to clk and filt_valid is a single-cycle strobe.
module conv_ready_ctrl
    import conv_ready_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int CHAN_W = 4,
    parameter int GAIN_W = 3,
    parameter int RATE_W = 10,
    parameter int S3_LEN = 3,
    parameter int S4_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              filt_valid,
    input  logic [DATA_W-1:0] filt_data,
    input  logic [CHAN_W-1:0] cfg_chan,
    input  logic [GAIN_W-1:0] cfg_gain,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic              order4,
    input  logic              zero_lat,
    input  logic              sync_n,
    input  logic              rd_done,
    output logic              drdy_n,
    output logic [DATA_W-1:0] dout,
    output logic              settled
);

    localparam int CFG_W = CHAN_W + GAIN_W + RATE_W + 2;

    logic [CFG_W-1:0] cfg_word;
    logic             chg;
    logic             publish;
    logic             flush;
    filt_order_e      order_sel;

    // Pack every field whose change must restart settling.
    always_comb begin
        cfg_word  = {zero_lat, order4, cfg_rate, cfg_gain, cfg_chan};
        order_sel = filt_order_e'(order4);
    end

    cfg_change_det #(
        .CFG_W (CFG_W)
    ) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_now (cfg_word),
        .chg     (chg)
    );

    settle_ctrl #(
        .S3_LEN (S3_LEN),
        .S4_LEN (S4_LEN)
    ) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (filt_valid),
        .chg       (chg),
        .zero_lat  (zero_lat),
        .order_sel (order_sel),
        .sync_n    (sync_n),
        .publish   (publish),
        .flush     (flush),
        .settled   (settled)
    );

    ready_out #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .publish (publish),
        .flush   (flush),
        .rd_done (rd_done),
        .data_in (filt_data),
        .dout    (dout),
        .drdy_n  (drdy_n)
    );

    // R1: ready stays high throughout reset.
    a_r1_reset_high: assert property (@(posedge clk)
        !rst_n |=> drdy_n);

endmodule

// File: tb/conv_ready_ctrl_bench.sv
module conv_ready_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        filt_valid = 1'b0;
    logic [23:0] filt_data = '0;
    logic [3:0]  cfg_chan = '0;
    logic [2:0]  cfg_gain = '0;
    logic [9:0]  cfg_rate = 10'd96;
    logic        order4 = 1'b1;
    logic        zero_lat = 1'b0;
    logic        sync_n = 1'b1;
    logic        rd_done = 1'b0;
    logic        drdy_n;
    logic [23:0] dout;
    logic        settled;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [23:0] exp_dout = '0;
    int          cyc = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    conv_ready_ctrl u_conv_ready_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .filt_valid (filt_valid),
        .filt_data  (filt_data),
        .cfg_chan   (cfg_chan),
        .cfg_gain   (cfg_gain),
        .cfg_rate   (cfg_rate),
        .order4     (order4),
        .zero_lat   (zero_lat),
        .sync_n     (sync_n),
        .rd_done    (rd_done),
        .drdy_n     (drdy_n),
        .dout       (dout),
        .settled    (settled)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply one filter strobe; returns at the negedge after the sampling edge.
    task automatic strobe(input logic [23:0] d);
        @(negedge clk);
        filt_valid = 1'b1;
        filt_data  = d;
        @(negedge clk);
        filt_valid = 1'b0;
    endtask

    // Strobe that must be discarded: output word unchanged, ready high.
    task automatic expect_drop(input logic [23:0] d, input string req);
        strobe(d);
        chk({req, " dout kept"}, 32'(dout), 32'(exp_dout));
        chk({req, " drdy high"}, 32'(drdy_n), 32'd1);
        chk({req, " unsettled"}, 32'(settled), 32'd0);
    endtask

    // Strobe that must be published, with the ready timing of R9.
    task automatic expect_pub(input logic [23:0] d, input string req);
        strobe(d);
        exp_dout = d;
        chk({req, " R9 dout loaded"}, 32'(dout), 32'(d));
        chk({req, " R9 drdy high on write"}, 32'(drdy_n), 32'd1);
        @(negedge clk);
        chk({req, " R9 drdy low"}, 32'(drdy_n), 32'd0);
        chk({req, " settled"}, 32'(settled), 32'd1);
    endtask

    task automatic t_reset;
        chk("R1 drdy_n", 32'(drdy_n), 32'd1);
        chk("R1 settled", 32'(settled), 32'd0);
        chk("R1 dout", 32'(dout), 32'd0);
    endtask

    task automatic t_sinc4_window;
        expect_drop(24'h000101, "R2 drop1");
        expect_drop(24'h000102, "R2 drop2");
        expect_drop(24'h000103, "R2 drop3");
        expect_pub(24'h000104, "R2 fourth");
    endtask

    task automatic t_steady;
        expect_pub(24'h123456, "R4 next");
        expect_pub(24'hFFF000, "R4 step unflagged");
    endtask

    task automatic t_read;
        @(negedge clk);
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        chk("R10 drdy high", 32'(drdy_n), 32'd1);
        chk("R10 dout kept", 32'(dout), 32'(exp_dout));
    endtask

    task automatic t_change;
        @(negedge clk);
        cfg_gain   = 3'd5;
        filt_valid = 1'b1;
        filt_data  = 24'hBAD001;
        @(negedge clk);
        filt_valid = 1'b0;
        chk("R5 settled cleared", 32'(settled), 32'd0);
        chk("R5 drdy high", 32'(drdy_n), 32'd1);
        chk("R5 same-cycle strobe dropped", 32'(dout), 32'(exp_dout));
        expect_drop(24'h000201, "R6 pre1");
        expect_drop(24'h000202, "R6 pre2");
        @(negedge clk);
        cfg_chan = 4'd3;
        expect_drop(24'h000203, "R6 post1");
        expect_drop(24'h000204, "R6 post2");
        expect_drop(24'h000205, "R6 post3");
        expect_pub(24'h000206, "R6 restarted");
    endtask

    task automatic t_sinc3;
        @(negedge clk);
        order4 = 1'b0;
        @(negedge clk);
        chk("R3 order change unsettles", 32'(settled), 32'd0);
        expect_drop(24'h000301, "R3 drop1");
        expect_drop(24'h000302, "R3 drop2");
        expect_pub(24'h000303, "R3 third");
    endtask

    task automatic t_zero;
        @(negedge clk);
        zero_lat = 1'b1;
        expect_pub(24'h000401, "R7 first");
        @(negedge clk);
        cfg_chan   = 4'd7;
        filt_valid = 1'b1;
        filt_data  = 24'h000402;
        @(negedge clk);
        filt_valid = 1'b0;
        exp_dout   = 24'h000402;
        chk("R7 change-cycle publish", 32'(dout), 32'(exp_dout));
        chk("R7 settled kept", 32'(settled), 32'd1);
        expect_pub(24'h000403, "R7 next");
    endtask

    task automatic t_sync;
        @(negedge clk);
        sync_n = 1'b0;
        expect_drop(24'h000501, "R8 ignored zero");
        @(negedge clk);
        sync_n = 1'b1;
        expect_pub(24'h000502, "R8 zero release");
        @(negedge clk);
        zero_lat = 1'b0;
        order4   = 1'b1;
        @(negedge clk);
        sync_n = 1'b0;
        expect_drop(24'h000503, "R8 ignored free");
        @(negedge clk);
        sync_n = 1'b1;
        expect_drop(24'h000504, "R8 free drop1");
        expect_drop(24'h000505, "R8 free drop2");
        expect_drop(24'h000506, "R8 free drop3");
        expect_pub(24'h000507, "R8 free fourth");
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sinc4_window();
        t_steady();
        t_read();
        t_change();
        t_sinc3();
        t_zero();
        t_sync();
        done = 1'b1;
        finish_run();
    end

endmodule